// File: doc/BRIEF.md
# Dynamic Priority Interrupt Arbiter

This block picks one interrupt line out of a set of up to three banks of 32 lines. Every line brings four things: a pending bit, a mask bit, a class bit that routes it to either the normal class or the fast class, and a programmable priority value. The arbiter looks only at the lines that belong to its own class, finds the most urgent one, and reports that line's global number together with a valid flag. It holds no state and has no clock: the result follows the inputs within the same cycle.

A controller uses two copies side by side. One copy is built for the normal class and the other for the fast class, and both are fed from the same pending, mask, class and priority storage. The controller owns register access, the capture of input events and the handshake towards the processor. It samples the winner index whenever it needs to present a new source number.

Top module: `prio_irq_arbiter`

## Requirements
- R1: A line takes part in arbitration only when its pending bit is 1 and its mask bit is 0; a masked or idle line is never reported, whatever its priority.
- R2: A line takes part only when its class bit equals the instance's class parameter (CLASS = CLS_IRQ selects lines whose class bit is 0, CLASS = CLS_FIQ selects lines whose class bit is 1).
- R3: Among the candidates, the one with the numerically smallest priority wins; priority 0 is the most urgent.
- R4: When several candidates share the best priority, the candidate with the largest global line number wins.
- R5: Line k occupies bit k of the pending, mask and class vectors and bits [k*PRIO_W +: PRIO_W] of the priority vector, where k = 32 * bank + bit position inside the bank; the winner output carries that k.
- R6: With no candidate, win_valid is 0 and win_idx is 0.
- R7: The outputs depend only on the present inputs: a change of any input is reflected at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| line_pend | input | NUM_BANKS*32 | Pending bit per line |
| line_mask | input | NUM_BANKS*32 | Mask bit per line, 1 blocks the line |
| line_cls | input | NUM_BANKS*32 | Class bit per line, 1 = fast class |
| line_prio | input | NUM_BANKS*32*PRIO_W | Priority per line, smaller is more urgent |
| win_valid | output | 1 | At least one candidate exists |
| win_idx | output | $clog2(NUM_BANKS*32) | Global number of the winning line, 0 when idle |

## Verification
Since the block holds no state, a wrong internal value can only be a wrong comparison or a wrong wire in the reduction tree, and it shows at the ports in the same cycle as the input pattern that exercises it: a worse priority or a lower line number on win_idx, a reported line that is masked or of the other class, or a valid flag that disagrees with the set of candidates. Directed vectors place the competing lines on bank edges and on both sides of tree splits, and random patterns compared against a linear scan reach the remaining comparison nodes.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int LINES_PER_BANK = 32;
    localparam int MAX_BANKS      = 3;

    // Which of the two interrupt classes an arbiter instance serves
    typedef enum logic {
        CLS_IRQ = 1'b0,
        CLS_FIQ = 1'b1
    } arb_class_e;
endpackage

// File: rtl/arb_qualify.sv
// Per-bank candidate filter: pending, unmasked and of the served class.
module arb_qualify #(
    parameter int                  WIDTH = arb_pkg::LINES_PER_BANK,
    parameter arb_pkg::arb_class_e CLASS = arb_pkg::CLS_IRQ
) (
    input  logic [WIDTH-1:0] pend,
    input  logic [WIDTH-1:0] mask,
    input  logic [WIDTH-1:0] cls,
    output logic [WIDTH-1:0] cand
);
    logic [WIDTH-1:0] cls_ok;

    generate
        if (CLASS == arb_pkg::CLS_FIQ) begin : g_fast
            assign cls_ok = cls;
        end else begin : g_norm
            assign cls_ok = ~cls;
        end
    endgenerate

    assign cand = pend & ~mask & cls_ok;
endmodule

// File: rtl/arb_pick.sv
// One node of the reduction tree. The "hi" side always covers higher line
// numbers than the "lo" side, so taking "hi" on equal priority gives the
// highest-numbered line among equals.
module arb_pick #(
    parameter int PRIO_W = 6,
    parameter int IDX_W  = 7
) (
    input  logic              lo_vld,
    input  logic [PRIO_W-1:0] lo_prio,
    input  logic [IDX_W-1:0]  lo_idx,
    input  logic              hi_vld,
    input  logic [PRIO_W-1:0] hi_prio,
    input  logic [IDX_W-1:0]  hi_idx,
    output logic              out_vld,
    output logic [PRIO_W-1:0] out_prio,
    output logic [IDX_W-1:0]  out_idx
);
    logic take_hi;

    always_comb begin
        take_hi  = hi_vld && (!lo_vld || (hi_prio <= lo_prio));
        out_vld  = lo_vld | hi_vld;
        out_prio = take_hi ? hi_prio : lo_prio;
        out_idx  = take_hi ? hi_idx  : lo_idx;
    end
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter #(
    parameter int                  NUM_BANKS = 3,
    parameter int                  PRIO_W    = 6,
    parameter arb_pkg::arb_class_e CLASS     = arb_pkg::CLS_IRQ,
    localparam int                 NUM_LINES = NUM_BANKS * arb_pkg::LINES_PER_BANK,
    localparam int                 IDX_W     = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0]        line_pend,
    input  logic [NUM_LINES-1:0]        line_mask,
    input  logic [NUM_LINES-1:0]        line_cls,
    input  logic [NUM_LINES*PRIO_W-1:0] line_prio,
    output logic                        win_valid,
    output logic [IDX_W-1:0]            win_idx
);
    localparam int BANK_W = arb_pkg::LINES_PER_BANK;
    localparam int LEAVES = 1 << IDX_W;
    localparam int NODES  = 2 * LEAVES - 1;

    logic [NUM_LINES-1:0] cand;

    // Heap-ordered tree: node n has children 2n+1 (lower lines) and 2n+2.
    logic              node_vld  [NODES];
    logic [PRIO_W-1:0] node_prio [NODES];
    logic [IDX_W-1:0]  node_idx  [NODES];

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            arb_qualify #(
                .WIDTH (BANK_W),
                .CLASS (CLASS)
            ) u_qual (
                .pend (line_pend[b*BANK_W +: BANK_W]),
                .mask (line_mask[b*BANK_W +: BANK_W]),
                .cls  (line_cls [b*BANK_W +: BANK_W]),
                .cand (cand     [b*BANK_W +: BANK_W])
            );
        end

        for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
            if (k < NUM_LINES) begin : g_real
                assign node_vld [LEAVES-1+k] = cand[k];
                assign node_prio[LEAVES-1+k] = line_prio[k*PRIO_W +: PRIO_W];
                assign node_idx [LEAVES-1+k] = IDX_W'(k);
            end else begin : g_pad
                assign node_vld [LEAVES-1+k] = 1'b0;
                assign node_prio[LEAVES-1+k] = '1;
                assign node_idx [LEAVES-1+k] = '0;
            end
        end

        for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
            arb_pick #(
                .PRIO_W (PRIO_W),
                .IDX_W  (IDX_W)
            ) u_pick (
                .lo_vld   (node_vld [2*n+1]),
                .lo_prio  (node_prio[2*n+1]),
                .lo_idx   (node_idx [2*n+1]),
                .hi_vld   (node_vld [2*n+2]),
                .hi_prio  (node_prio[2*n+2]),
                .hi_idx   (node_idx [2*n+2]),
                .out_vld  (node_vld [n]),
                .out_prio (node_prio[n]),
                .out_idx  (node_idx [n])
            );
        end
    endgenerate

    assign win_valid = node_vld[0];
    assign win_idx   = node_vld[0] ? node_idx[0] : '0;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
    parameter int                  NUM_BANKS = 3,
    parameter int                  PRIO_W    = 6,
    parameter arb_pkg::arb_class_e CLASS     = arb_pkg::CLS_IRQ,
    localparam int                 NUM_LINES = NUM_BANKS * arb_pkg::LINES_PER_BANK,
    localparam int                 IDX_W     = $clog2(NUM_LINES)
) (
    input logic [NUM_LINES-1:0]        line_pend,
    input logic [NUM_LINES-1:0]        line_mask,
    input logic [NUM_LINES-1:0]        line_cls,
    input logic [NUM_LINES*PRIO_W-1:0] line_prio,
    input logic                        win_valid,
    input logic [IDX_W-1:0]            win_idx
);
    always_comb begin
        automatic logic known     = !$isunknown({line_pend, line_mask, line_cls, line_prio});
        automatic logic any_cand  = 1'b0;
        automatic logic beaten    = 1'b0;
        automatic logic win_ok    = 1'b0;
        automatic int   wi        = int'(win_idx);
        automatic logic [PRIO_W-1:0] wp = '0;
        if (wi < NUM_LINES) begin
            wp     = line_prio[wi*PRIO_W +: PRIO_W];
            win_ok = line_pend[wi] && !line_mask[wi] && (line_cls[wi] == logic'(CLASS));
        end
        for (int k = 0; k < NUM_LINES; k++) begin
            if (line_pend[k] && !line_mask[k] && (line_cls[k] == logic'(CLASS))) begin
                any_cand = 1'b1;
                if ((line_prio[k*PRIO_W +: PRIO_W] < wp) ||
                    ((line_prio[k*PRIO_W +: PRIO_W] == wp) && (k > wi)))
                    beaten = 1'b1;
            end
        end
        if (known) begin
            // R1 R2: the reported line is a real candidate of this class
            a_r1_r2_winner_eligible: assert (!win_valid || win_ok)
                else $error("winner %0d is not an eligible line", wi);
            // R6: valid flag tracks the candidate set; idle index is zero
            a_r6_valid_tracks_cands: assert (win_valid == any_cand)
                else $error("valid %0b with candidates %0b", win_valid, any_cand);
            a_r6_idle_index_zero: assert (win_valid || (win_idx == '0))
                else $error("idle index %0d", wi);
            // R3 R4: no candidate is more urgent, or equal and higher-numbered
            a_r3_r4_no_better_line: assert (!win_valid || !beaten)
                else $error("winner %0d beaten by another candidate", wi);
            // R5: the index names an existing line
            a_r5_index_in_range: assert (wi < NUM_LINES)
                else $error("index %0d out of range", wi);
        end
    end
endmodule

bind prio_irq_arbiter arb_checker #(
    .NUM_BANKS (NUM_BANKS),
    .PRIO_W    (PRIO_W),
    .CLASS     (CLASS)
) u_chk (
    .line_pend (line_pend),
    .line_mask (line_mask),
    .line_cls  (line_cls),
    .line_prio (line_prio),
    .win_valid (win_valid),
    .win_idx   (win_idx)
);

// File: tb/prio_irq_arbiter_tb.sv
module prio_irq_arbiter_tb;
    localparam int NB = 3;
    localparam int PW = 6;
    localparam int NL = NB * 32;
    localparam int IW = $clog2(NL);

    // Each row: line A, prio A, line B, prio B, expected normal-class winner
    localparam int NVEC = 8;
    localparam int VEC [NVEC][5] = '{
        '{ 3,  5, 70,  5, 70},
        '{ 3,  2, 70,  5,  3},
        '{95, 63,  0, 63, 95},
        '{ 0,  0, 95,  1,  0},
        '{31,  7, 32,  7, 32},
        '{64, 10, 63, 10, 64},
        '{40,  0, 41,  0, 41},
        '{10, 62, 11, 63, 10}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [NL-1:0]    pend = '0;
    logic [NL-1:0]    msk  = '0;
    logic [NL-1:0]    cls  = '0;
    logic [NL*PW-1:0] prio = '0;
    logic             n_vld, f_vld;
    logic [IW-1:0]    n_idx, f_idx;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    prio_irq_arbiter #(.NUM_BANKS(NB), .PRIO_W(PW), .CLASS(arb_pkg::CLS_IRQ)) u_dut (
        .line_pend(pend), .line_mask(msk), .line_cls(cls), .line_prio(prio),
        .win_valid(n_vld), .win_idx(n_idx));

    prio_irq_arbiter #(.NUM_BANKS(NB), .PRIO_W(PW), .CLASS(arb_pkg::CLS_FIQ)) u_dut_fiq (
        .line_pend(pend), .line_mask(msk), .line_cls(cls), .line_prio(prio),
        .win_valid(f_vld), .win_idx(f_idx));

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Linear scan from line 0 upward; "<=" lets a later equal line take over.
    task automatic ref_pick(input bit fiq, output bit vld, output int idx);
        int best;
        vld = 0; idx = 0; best = 0;
        for (int k = 0; k < NL; k++) begin
            if (pend[k] && !msk[k] && (cls[k] == fiq)) begin
                if (!vld || int'(prio[k*PW +: PW]) <= best) begin
                    vld = 1; idx = k; best = int'(prio[k*PW +: PW]);
                end
            end
        end
    endtask

    task automatic clear_all();
        pend = '0; msk = '0; cls = '0; prio = '0;
    endtask

    task automatic set_line(input int k, input int p, input bit c);
        pend[k] = 1'b1; msk[k] = 1'b0; cls[k] = c; prio[k*PW +: PW] = PW'(p);
    endtask

    task automatic settle();
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit rv; int ri;
        repeat (3) @(posedge clk);
        #2;
        // R6: everything idle during and after reset
        check("R6 idle valid", int'(n_vld), 0);
        check("R6 idle index", int'(n_idx), 0);
        check("R6 idle fast valid", int'(f_vld), 0);
        rst_n = 1'b1;

        // Table walk: R3 R4 R5
        for (int v = 0; v < NVEC; v++) begin
            settle();
            clear_all();
            set_line(VEC[v][0], VEC[v][1], 1'b0);
            set_line(VEC[v][2], VEC[v][3], 1'b0);
            #1;
            check($sformatf("R3 R4 R5 vector %0d idx", v), int'(n_idx), VEC[v][4]);
            check($sformatf("R3 R4 R5 vector %0d valid", v), int'(n_vld), 1);
            check($sformatf("R2 vector %0d fast idle", v), int'(f_vld), 0);
        end

        // R1: best-priority line masked, then not pending
        settle(); clear_all();
        set_line(20, 0, 1'b0); set_line(50, 9, 1'b0);
        msk[20] = 1'b1;
        #1 check("R1 masked line skipped", int'(n_idx), 50);
        msk[20] = 1'b0; pend[20] = 1'b0; msk[50] = 1'b1;
        #1 check("R1 no candidate left valid", int'(n_vld), 0);
        check("R6 no candidate index", int'(n_idx), 0);

        // R2: class split between the two instances
        settle(); clear_all();
        set_line(7, 0, 1'b1); set_line(88, 30, 1'b0); set_line(90, 30, 1'b1);
        #1;
        check("R2 normal class winner", int'(n_idx), 88);
        check("R2 fast class winner", int'(f_idx), 7);

        // R7: no clock edge between input change and observation
        @(negedge clk);
        prio[90*PW +: PW] = '0;
        #1 check("R7 follows input without clock", int'(f_idx), 90);
        pend = '0;
        #1 check("R7 drop without clock", int'(f_vld), 0);

        // R6: all pending but all masked
        settle(); clear_all();
        pend = '1; msk = '1;
        #1 check("R6 all masked valid", int'(n_vld), 0);
        check("R6 all masked fast valid", int'(f_vld), 0);

        // Random patterns against the linear scan: R1..R5
        for (int it = 0; it < 400; it++) begin
            settle();
            for (int k = 0; k < NL; k++) begin
                pend[k] = ($urandom_range(0, 3) != 0);
                msk[k]  = ($urandom_range(0, 2) == 0);
                cls[k]  = ($urandom_range(0, 3) == 0);
                prio[k*PW +: PW] = (it % 2 == 0) ? PW'($urandom_range(0, 3))
                                                 : PW'($urandom);
            end
            if (it % 50 == 0) pend = '0;
            #1;
            ref_pick(1'b0, rv, ri);
            check("R3 R4 random normal valid", int'(n_vld), int'(rv));
            check("R3 R4 random normal idx", int'(n_idx), ri);
            ref_pick(1'b1, rv, ri);
            check("R1 R2 random fast valid", int'(f_vld), int'(rv));
            check("R5 random fast idx", int'(f_idx), ri);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule